// File: doc/BRIEF.md
# Interrupt Pin Redirector with Message Output

The block turns a set of interrupt request pins into memory-write style interrupt messages. Each pin has a 64-bit routing entry. The entry gives a vector, a delivery mode, a destination and destination mode, and a level/edge selector and a mask. The routing table is supplied from outside as one flat vector. The block keeps a pending-request bit for each pin and an in-service bit for each level pin. It scans for pins that can be delivered and presents one message at a time, as a 32-bit address and a 32-bit data word, on a valid/ready port.

Edge pins latch a rising request only while they are unmasked. The pending bit clears when the message leaves. Level pins follow their input. A level pin sends one message and then stays quiet while its in-service bit is set. The in-service bit drops when the entry is reconfigured as edge-triggered. Request pin 0 is folded onto slot 2.

Top module: `irq_redirect`

## Requirements
- R1: After reset, `msg_valid` is 0 and `in_service` is all zeros.
- R2: A request on pin 0 is treated as a request on slot 2: it produces a message built from entry 2, and entry 0 never produces a message. Pin 2 still drives slot 2.
- R3: A level entry (bit 15 = 1), unmasked (bit 16 = 0), whose input is high and whose in-service bit is clear, sends exactly one message and sets its `in_service` bit. While that bit stays set, no further message is sent, even though the input stays high.
- R4: A level request that is deasserted before it can be delivered is forgotten: unmasking the entry afterwards produces no message.
- R5: A rising edge on an edge entry (bit 15 = 0) that is masked (bit 16 = 1) is dropped: unmasking the entry later produces no message.
- R6: A rising edge on an unmasked edge entry produces exactly one message. Holding the pin high adds nothing, and a later fresh rising edge produces another message.
- R7: An `in_service` bit is only ever set for a level entry, and it clears once that entry's trigger bit is changed to edge.
- R8: The message address is 0xFEE00000 OR (entry bits 63:48 shifted left by 12) OR (entry bit 11 shifted left by 2).
- R9: The message data word holds the vector (entry bits 7:0) in bits 7:0, the delivery mode (entry bits 10:8) in bits 10:8 and the trigger bit in bit 15. All other data bits are 0.
- R10: At most one message is issued per cycle. While a message is held (`msg_valid` high, `msg_ready` low), address and data stay stable. Candidates are served in ascending slot order, starting at the slot after the last one delivered and wrapping from 23 to 0.
- R11: Bit 14 of a table entry has no effect: the in-service state is tracked inside the block.
- R12: A level request that is raised while its entry is masked is delivered once the entry is unmasked, as long as the input is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | 24 | Interrupt request pins |
| route_tbl | input | 1536 | Routing entries, slot n in bits n*64+63 : n*64 |
| in_service | output | 24 | In-service bit for each slot (level entries only) |
| msg_valid | output | 1 | A message is presented |
| msg_ready | input | 1 | The consumer accepts the presented message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The assertions assume that `msg_ready` and the routing table change only between clock edges. They also assume that a held message is not withdrawn by the consumer side. The stimulus changes pins, table entries and `msg_ready` only on falling edges. It raises and lowers each pin cleanly, holding it for at least one cycle. Each table change happens while no message for that slot is in flight.

// File: rtl/irq_redirect.sv
module irq_redirect #(
  parameter int          NPINS     = 24,
  parameter logic [31:0] MSG_BASE  = 32'hFEE0_0000,
  parameter int          ALIAS_SRC = 0,
  parameter int          ALIAS_DST = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   irq_pins,
  input  logic [NPINS*64-1:0] route_tbl,
  output logic [NPINS-1:0]   in_service,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int IW = $clog2(NPINS);

  logic [NPINS-1:0] lvl, lvl_q, rise;
  logic [NPINS-1:0] irr_q, irr_d, rirr_q, rirr_d;
  logic [NPINS-1:0] mask_b, trig_lvl, cand, take;
  logic [NPINS-1:0] unused_tbl;
  logic [IW-1:0]    ptr, ptr_d, sel;
  logic             found, advance;
  logic [63:0]      sel_ent;
  logic [31:0]      addr_d, data_d;

  always_comb begin
    lvl = irq_pins;
    lvl[ALIAS_DST] = irq_pins[ALIAS_DST] | irq_pins[ALIAS_SRC];
    lvl[ALIAS_SRC] = 1'b0;
  end

  assign rise = lvl & ~lvl_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_slot
    assign mask_b[g]     = route_tbl[g*64+16];
    assign trig_lvl[g]   = route_tbl[g*64+15];
    assign unused_tbl[g] = ^{route_tbl[g*64+12 +: 3], route_tbl[g*64+17 +: 31]};
    assign take[g]       = advance && (sel == IW'(g));
    assign cand[g]       = irr_q[g] & ~mask_b[g] & ~(trig_lvl[g] & rirr_q[g]);
    assign irr_d[g]      = trig_lvl[g] ? lvl[g]
                         : ((irr_q[g] & ~take[g]) | (rise[g] & ~mask_b[g]));
    assign rirr_d[g]     = trig_lvl[g] & (rirr_q[g] | take[g]);
  end

  always_comb begin
    int idx;
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < NPINS; k++) begin
      idx = int'(ptr) + k;
      if (idx >= NPINS) idx = idx - NPINS;
      if (!found && cand[idx]) begin
        found = 1'b1;
        sel   = idx[IW-1:0];
      end
    end
  end

  assign advance = found && (!msg_valid || msg_ready);
  assign ptr_d   = (sel == IW'(NPINS-1)) ? '0 : sel + 1'b1;
  assign sel_ent = route_tbl[int'(sel)*64 +: 64];
  assign addr_d  = MSG_BASE | (32'(sel_ent[63:48]) << 12) | {29'b0, sel_ent[11], 2'b00};
  assign data_d  = {16'b0, sel_ent[15], 4'b0, sel_ent[10:8], sel_ent[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= '0;
      irr_q     <= '0;
      rirr_q    <= '0;
      ptr       <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      lvl_q  <= lvl;
      irr_q  <= irr_d;
      rirr_q <= rirr_d;
      if (advance) begin
        msg_valid <= 1'b1;
        msg_addr  <= addr_d;
        msg_data  <= data_d;
        ptr       <= ptr_d;
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  assign in_service = rirr_q;
endmodule

// File: rtl/irq_redirect_chk.sv
module irq_redirect_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] lvl_mask,
  input logic [NPINS-1:0] in_service,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R8
  addr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[31:28] == 4'hF) && ((msg_addr & 32'h0000_0FFB) == 32'h0));

  // R9
  data_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:16] == 16'h0) && (msg_data[14:11] == 4'h0));

  // R7
  svc_level_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service & ~$past(lvl_mask)) == '0);

  // R3
  svc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(in_service) & $past(lvl_mask)) & ~in_service) == '0);

  // R10
  one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_service & ~$past(in_service)) <= 1);

  // R3
  svc_with_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_service & ~$past(in_service)) != '0) |-> msg_valid);
endmodule

bind irq_redirect irq_redirect_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lvl_mask   (trig_lvl),
  .in_service (in_service),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_addr   (msg_addr),
  .msg_data   (msg_data)
);

// File: tb/irq_redirect_test.sv
module irq_redirect_test;
  localparam int N = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     pins = '0;
  logic [N*64-1:0]  tbl = '0;
  logic [N-1:0]     in_service;
  logic             msg_valid;
  logic             ready = 1'b1;
  logic [31:0]      msg_addr, msg_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_redirect uut (
    .clk(clk), .rst_n(rst_n), .irq_pins(pins), .route_tbl(tbl),
    .in_service(in_service), .msg_valid(msg_valid), .msg_ready(ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_entry(input int p, input logic [7:0] vec, input logic [2:0] dm,
                           input logic dmode, input logic lvl, input logic msk,
                           input logic [15:0] dest, input logic rbit);
    tbl[p*64 +: 64] = {dest, 31'b0, msk, lvl, rbit, 2'b00, dmode, dm, vec};
  endtask

  task automatic expect_msg(input int p, input string req);
    logic [63:0] e;
    logic [31:0] a, d;
    e = tbl[p*64 +: 64];
    a = 32'hFEE0_0000 | (32'(e[63:48]) << 12) | (32'(e[11]) << 2);
    d = {16'b0, e[15], 4'b0, e[10:8], e[7:0]};
    exp_q.push_back({a, d});
    tag_q.push_back(req);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    tag_q.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n && msg_valid && ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R4/R5/R6 unexpected message", {msg_addr, msg_data}, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({msg_addr, msg_data} == e, t, {msg_addr, msg_data}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R10 watchdog", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_a, held_d;
    for (int p = 0; p < N; p++) set_entry(p, 8'(8'h20 + p), 3'd0, 1'b0, 1'b0, 1'b1, 16'h0, 1'b0);
    cyc(3);
    // R1
    check(msg_valid == 1'b0, "R1 valid", 64'(msg_valid), 64'd0);
    check(in_service == '0, "R1 in_service", 64'(in_service), 64'd0);
    rst_n = 1'b1;
    cyc(3);

    // R6, R8, R9: edge delivery and message format
    set_entry(5, 8'h35, 3'd3, 1'b1, 1'b0, 1'b0, 16'h1234, 1'b0);
    expect_msg(5, "R6 R8 R9 edge pin5");
    pins[5] = 1'b1; cyc(8); pins[5] = 1'b0; cyc(4);
    drained("R6 single message while held");
    expect_msg(5, "R6 second edge pin5");
    pins[5] = 1'b1; cyc(2); pins[5] = 1'b0; cyc(6);
    drained("R6 second edge");
    set_entry(6, 8'hFF, 3'd7, 1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b0);
    expect_msg(6, "R8 R9 all-ones fields pin6");
    pins[6] = 1'b1; cyc(2); pins[6] = 1'b0; cyc(6);
    drained("R8 R9 pin6");

    // R5: masked edge dropped
    set_entry(7, 8'h47, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0007, 1'b0);
    pins[7] = 1'b1; cyc(2); pins[7] = 1'b0; cyc(2);
    set_entry(7, 8'h47, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0007, 1'b0);
    cyc(8);
    drained("R5 masked edge dropped");

    // R3: level delivery once
    set_entry(9, 8'h49, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0909, 1'b0);
    expect_msg(9, "R3 level pin9");
    pins[9] = 1'b1; cyc(20);
    check(in_service[9] == 1'b1, "R3 in_service set", 64'(in_service), 64'h200);
    drained("R3 no repeat while in service");
    pins[9] = 1'b0; cyc(2);

    // R7: switch to edge clears in-service
    set_entry(9, 8'h49, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0909, 1'b0);
    cyc(3);
    check(in_service[9] == 1'b0, "R7 cleared by edge mode", 64'(in_service), 64'd0);
    set_entry(9, 8'h49, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0909, 1'b0);
    cyc(6);
    drained("R7 no message after mode change");

    // R4: deasserted level request forgotten
    set_entry(10, 8'h5A, 3'd2, 1'b1, 1'b1, 1'b1, 16'h00A0, 1'b0);
    pins[10] = 1'b1; cyc(5); pins[10] = 1'b0; cyc(3);
    set_entry(10, 8'h5A, 3'd2, 1'b1, 1'b1, 1'b0, 16'h00A0, 1'b0);
    cyc(8);
    drained("R4 dropped level request");
    // R12: masked level held high is delivered on unmask
    set_entry(10, 8'h5A, 3'd2, 1'b1, 1'b1, 1'b1, 16'h00A0, 1'b0);
    pins[10] = 1'b1; cyc(6);
    drained("R12 nothing while masked");
    set_entry(10, 8'h5A, 3'd2, 1'b1, 1'b1, 1'b0, 16'h00A0, 1'b0);
    expect_msg(10, "R12 delivered on unmask");
    cyc(6);
    drained("R12 delivered on unmask");
    pins[10] = 1'b0; cyc(2);

    // R2: pin 0 folded onto slot 2
    set_entry(0, 8'h60, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0);
    set_entry(2, 8'h62, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0022, 1'b0);
    expect_msg(2, "R2 pin0 uses entry 2");
    pins[0] = 1'b1; cyc(2); pins[0] = 1'b0; cyc(6);
    drained("R2 pin0");
    expect_msg(2, "R2 pin2 uses entry 2");
    pins[2] = 1'b1; cyc(2); pins[2] = 1'b0; cyc(6);
    drained("R2 pin2");

    // R11: table bit 14 ignored
    set_entry(11, 8'h6B, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0B0B, 1'b1);
    expect_msg(11, "R11 bit14 ignored");
    pins[11] = 1'b1; cyc(6);
    check(in_service[11] == 1'b1, "R11 in_service", 64'(in_service), 64'h800);
    drained("R11 delivered");
    pins[11] = 1'b0; cyc(2);

    // R10: stall and ordering (last delivered slot 11)
    ready = 1'b0;
    set_entry(12, 8'h7C, 3'd0, 1'b0, 1'b0, 1'b0, 16'h000C, 1'b0);
    set_entry(13, 8'h7D, 3'd0, 1'b0, 1'b0, 1'b0, 16'h000D, 1'b0);
    set_entry(14, 8'h7E, 3'd0, 1'b0, 1'b0, 1'b0, 16'h000E, 1'b0);
    expect_msg(12, "R10 order 12");
    expect_msg(13, "R10 order 13");
    expect_msg(14, "R10 order 14");
    pins[14] = 1'b1; pins[12] = 1'b1; pins[13] = 1'b1;
    cyc(4);
    check(msg_valid && msg_data[7:0] == 8'h7C, "R10 first held is slot 12", {31'b0, msg_valid, msg_data}, {32'd1, 32'h7C});
    held_a = msg_addr; held_d = msg_data;
    cyc(6);
    check(msg_valid && msg_addr == held_a && msg_data == held_d, "R10 stable while stalled",
          {msg_addr, msg_data}, {held_a, held_d});
    ready = 1'b1;
    cyc(8);
    drained("R10 ascending drain");
    pins[12] = 1'b0; pins[13] = 1'b0; pins[14] = 1'b0; cyc(2);
    set_entry(3, 8'h83, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0003, 1'b0);
    set_entry(20, 8'h94, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0014, 1'b0);
    expect_msg(20, "R10 wrap 20 first");
    expect_msg(3, "R10 wrap 3 second");
    pins[3] = 1'b1; pins[20] = 1'b1; cyc(2); pins[3] = 1'b0; pins[20] = 1'b0;
    cyc(8);
    drained("R10 wrap order");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule